// File: doc/BRIEF.md
# Redistributor group power controller

This block holds the power-control state for a group of interrupt redistributor frames, each of which can be gated on its own, together with the power state of the group they share. Software reaches it through a 32-bit register slave with a valid/ready request channel and a registered read response. Each frame has an address window of its own, and each window holds a power register and an identification register.

Software asks for a frame to be powered on or off by writing that frame's power register, then re-reads the register until the state it asked for shows. The group follows the frames. The first power-on request while the group is down starts a group power-up. Switching off the last frame that is still requested on starts a group power-down. Each transition lasts a parameterised number of cycles. While a transition is running, the group-down and group-off status bits read different values. A power-down can be aborted from a dedicated input, and the group then settles back in the powered state.

Top module: `rgp_pwr_ctrl`

## Requirements
- R1: After reset every frame's power register reads 0x0000000D: bit 0 = 1 (frame off), bit 1 = 0, bit 2 = 1 and bit 3 = 1 (group off and stable).
- R2: The power register sits at byte offset 0x24 of each frame's window. The frame index is taken from the address bits above the low WIN_BITS bits. The read layout is: bit 0 actual frame off status, bit 1 autonomous-control select, bit 2 group power-down status, bit 3 group power-off status; the upper bits read 0.
- R3: Offset 0x08 of every frame window reads ID_VALUE. Any other offset reads 0, and a write to any other offset changes no state.
- R4: While the group is off, writing a value with bit 0 = 0 and bit 1 = 0 starts a group power-up. Bit 2 reads 0 from the next cycle on. Bit 3 reads 1 for exactly UP_LAT cycles after the write and then reads 0, and the frame's bit 0 clears in the same cycle as bit 3.
- R5: While the group is on and stable, a write with bit 0 = 0 and bit 1 = 0 makes that frame's bit 0 read 0 in the cycle after the write.
- R6: Writing bit 0 = 1 makes the frame's bit 0 read 1 in the cycle after the write. If no frame is then still requested on, the group powers down: bit 2 reads 1 from the next cycle, bit 3 reads 0 for exactly DN_LAT cycles, and then both bits read 1.
- R7: A power-register write accepted while bit 2 and bit 3 differ is ignored. The frame request and bit 1 both stay as they were.
- R8: If grp_abort is high in any cycle of a power-down window, then at the end of that window bit 2 returns to 0 and bit 3 stays 0, so the group is stable and on.
- R9: Every accepted power-register write while the group is stable stores bit 1. A write with bit 0 = 0 and bit 1 = 1 does not request power-on.
- R10: req_ready is always 1. rsp_valid is 1 exactly in the cycle after an accepted read, and the data reflects the state before that read's own clock edge. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | WIN_BITS+IDX_W (10) | Byte address: frame index above a WIN_BITS-bit offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| grp_abort | input | 1 | Abort request for a running group power-down |

## Verification
A group state machine that is stuck or miscounted shows up in any frame's bits 2 and 3. The bench detects it within one read after the window should have closed, because it counts how many consecutive reads return the transition pattern. A corrupt frame request or select bit shows up in that frame's bit 0 or bit 1 at the next read after the write, or at the first read after the next group transition. That covers ignored writes made during a transition, whose effect would only appear once the group is stable again. A missed abort shows up as bit 3 reading 1 on the first read after the down window ends.

// File: rtl/rgp_pkg.sv
package rgp_pkg;

    localparam int unsigned REG_W = 32;

    // Byte offsets inside one frame window
    localparam logic [7:0] PWR_REG_OFS = 8'h24;
    localparam logic [7:0] ID_REG_OFS  = 8'h08;

    typedef enum logic [1:0] {
        GRP_OFF  = 2'd0,
        GRP_UP   = 2'd1,
        GRP_ON   = 2'd2,
        GRP_DOWN = 2'd3
    } grp_state_e;

    typedef struct packed {
        logic req_off;
        logic req_on;
        logic auto_sel;
    } pwr_cmd_t;

    function automatic pwr_cmd_t decode_pwr_word(input logic [1:0] w);
        pwr_cmd_t c;
        c.req_off  = w[0];
        c.req_on   = !w[0] && !w[1];
        c.auto_sel = w[1];
        return c;
    endfunction

    // Group power-down status: set from the start of a down transition until power-up begins
    function automatic logic grp_down_bit(input grp_state_e s);
        return (s == GRP_DOWN) || (s == GRP_OFF);
    endfunction

    // Group power-off status: set from the end of a down transition until the end of power-up
    function automatic logic grp_off_bit(input grp_state_e s);
        return (s == GRP_OFF) || (s == GRP_UP);
    endfunction

    function automatic logic grp_stable(input grp_state_e s);
        return (s == GRP_OFF) || (s == GRP_ON);
    endfunction

    function automatic logic [REG_W-1:0] pack_pwr_word(input logic frame_off, input logic auto_sel,
                                                       input logic gdown, input logic goff);
        return {{(REG_W-4){1'b0}}, goff, gdown, auto_sel, frame_off};
    endfunction

endpackage

// File: rtl/rgp_decode.sv
module rgp_decode
    import rgp_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned WIN_BITS   = 8,
    parameter int unsigned IDX_W      = 2
) (
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [WIN_BITS+IDX_W-1:0] req_addr,
    input  logic [1:0]                wbits,
    output logic [NUM_FRAMES-1:0]     pwr_wr_sel,
    output pwr_cmd_t                  cmd,
    output logic                      rd_en,
    output logic [IDX_W-1:0]          rd_idx,
    output logic                      rd_is_pwr,
    output logic                      rd_is_id
);
    logic [IDX_W-1:0]    idx;
    logic [WIN_BITS-1:0] ofs;
    logic                hit;
    logic                is_pwr;
    logic                is_id;

    assign idx    = req_addr[WIN_BITS +: IDX_W];
    assign ofs    = req_addr[WIN_BITS-1:0];
    assign hit    = ({1'b0, idx} < (IDX_W+1)'(NUM_FRAMES));
    assign is_pwr = hit && (ofs == WIN_BITS'(PWR_REG_OFS));
    assign is_id  = hit && (ofs == WIN_BITS'(ID_REG_OFS));

    assign cmd       = decode_pwr_word(wbits);
    assign rd_en     = req_valid && !req_write;
    assign rd_idx    = idx;
    assign rd_is_pwr = is_pwr;
    assign rd_is_id  = is_id;

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_sel
        assign pwr_wr_sel[f] = req_valid && req_write && is_pwr && (idx == IDX_W'(f));
    end
endmodule

// File: rtl/rgp_frame.sv
module rgp_frame
    import rgp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  pwr_cmd_t cmd,
    input  logic     grp_on_d,
    output logic     req_d,
    output logic     on_q,
    output logic     auto_q
);
    logic req_q;
    logic auto_d;

    always_comb begin
        req_d = req_q;
        if (wr_en) begin
            if (cmd.req_off)
                req_d = 1'b0;
            else if (cmd.req_on)
                req_d = 1'b1;
        end
        auto_d = wr_en ? cmd.auto_sel : auto_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            on_q   <= 1'b0;
            auto_q <= 1'b0;
        end else begin
            req_q  <= req_d;
            auto_q <= auto_d;
            on_q   <= req_d && grp_on_d;
        end
    end
endmodule

// File: rtl/rgp_group.sv
module rgp_group
    import rgp_pkg::*;
#(
    parameter int unsigned UP_LAT = 16,
    parameter int unsigned DN_LAT = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_up,
    input  logic       start_down,
    input  logic       abort,
    output grp_state_e state_q,
    output grp_state_e state_d
);
    localparam int unsigned MAX_LAT = (UP_LAT > DN_LAT) ? UP_LAT : DN_LAT;
    localparam int unsigned CW      = (MAX_LAT > 1) ? $clog2(MAX_LAT + 1) : 1;

    logic [CW-1:0] cnt_q, cnt_d;
    logic          abf_q, abf_d;
    logic          abort_any;

    assign abort_any = abf_q || abort;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        abf_d   = abf_q;
        unique case (state_q)
            GRP_OFF: begin
                if (start_up) begin
                    state_d = GRP_UP;
                    cnt_d   = CW'(UP_LAT - 1);
                end
            end
            GRP_UP: begin
                if (cnt_q == '0)
                    state_d = GRP_ON;
                else
                    cnt_d = cnt_q - 1'b1;
            end
            GRP_ON: begin
                if (start_down) begin
                    state_d = GRP_DOWN;
                    cnt_d   = CW'(DN_LAT - 1);
                    abf_d   = 1'b0;
                end
            end
            GRP_DOWN: begin
                abf_d = abort_any;
                if (cnt_q == '0) begin
                    state_d = abort_any ? GRP_ON : GRP_OFF;
                    abf_d   = 1'b0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = GRP_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GRP_OFF;
            cnt_q   <= '0;
            abf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            abf_q   <= abf_d;
        end
    end
endmodule

// File: rtl/rgp_pwr_ctrl.sv
module rgp_pwr_ctrl
    import rgp_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned WIN_BITS   = 8,
    parameter int unsigned UP_LAT     = 16,
    parameter int unsigned DN_LAT     = 24,
    parameter logic [31:0] ID_VALUE   = 32'h0200043B,
    localparam int unsigned IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int unsigned ADDR_W    = WIN_BITS + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              grp_abort
);
    logic [NUM_FRAMES-1:0] pwr_wr_sel;
    logic [NUM_FRAMES-1:0] wr_ok;
    logic [NUM_FRAMES-1:0] req_vec;
    logic [NUM_FRAMES-1:0] on_vec;
    logic [NUM_FRAMES-1:0] auto_vec;
    logic [NUM_FRAMES-1:0] frame_off;
    pwr_cmd_t              cmd;
    logic                  rd_en;
    logic [IDX_W-1:0]      rd_idx;
    logic                  rd_is_pwr;
    logic                  rd_is_id;
    grp_state_e            grp_q, grp_d;
    logic                  gpd, gpo;
    logic                  any_wr;
    logic                  start_up, start_down;
    logic [31:0]           rdata_d;
    logic [29:0]           wdata_hi_unused;

    assign req_ready       = 1'b1;
    assign wdata_hi_unused = req_wdata[31:2];

    rgp_decode #(
        .NUM_FRAMES(NUM_FRAMES),
        .WIN_BITS  (WIN_BITS),
        .IDX_W     (IDX_W)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .wbits     (req_wdata[1:0]),
        .pwr_wr_sel(pwr_wr_sel),
        .cmd       (cmd),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_is_pwr (rd_is_pwr),
        .rd_is_id  (rd_is_id)
    );

    // Power writes only land while the group is stable
    assign wr_ok      = pwr_wr_sel & {NUM_FRAMES{grp_stable(grp_q)}};
    assign any_wr     = |wr_ok;
    assign start_up   = any_wr && cmd.req_on;
    assign start_down = any_wr && cmd.req_off && (req_vec == '0);

    rgp_group #(
        .UP_LAT(UP_LAT),
        .DN_LAT(DN_LAT)
    ) u_group (
        .clk       (clk),
        .rst       (rst),
        .start_up  (start_up),
        .start_down(start_down),
        .abort     (grp_abort),
        .state_q   (grp_q),
        .state_d   (grp_d)
    );

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        rgp_frame u_frame (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_ok[f]),
            .cmd     (cmd),
            .grp_on_d(grp_d == GRP_ON),
            .req_d   (req_vec[f]),
            .on_q    (on_vec[f]),
            .auto_q  (auto_vec[f])
        );
    end

    assign frame_off = ~on_vec;
    assign gpd       = grp_down_bit(grp_q);
    assign gpo       = grp_off_bit(grp_q);

    always_comb begin
        rdata_d = '0;
        if (rd_is_pwr)
            rdata_d = pack_pwr_word(frame_off[rd_idx], auto_vec[rd_idx], gpd, gpo);
        else if (rd_is_id)
            rdata_d = ID_VALUE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rdata_d : '0;
        end
    end
endmodule

// File: rtl/rgp_checker.sv
module rgp_checker #(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned UP_LAT     = 16,
    parameter int unsigned DN_LAT     = 24
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  rsp_valid,
    input logic                  grp_abort,
    input logic                  gpd,
    input logic                  gpo,
    input logic [NUM_FRAMES-1:0] frame_off,
    input logic [NUM_FRAMES-1:0] auto_vec
);
    localparam int unsigned MAX_LAT = (UP_LAT > DN_LAT) ? UP_LAT : DN_LAT;

    int unsigned win_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            win_cnt <= 0;
        else if (gpd != gpo)
            win_cnt <= win_cnt + 1;
        else
            win_cnt <= 0;
    end

    // R1
    a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((&frame_off) && gpd && gpo));

    // R4
    a_r4_frame_needs_group: assert property (@(posedge clk) disable iff (rst)
        !(&frame_off) |-> (!gpd && !gpo));

    // R4, R6
    a_r4_window_bound: assert property (@(posedge clk) disable iff (rst)
        win_cnt <= MAX_LAT);

    // R6
    a_r6_down_ends_off: assert property (@(posedge clk) disable iff (rst)
        ($past(gpd && !gpo) && gpo) |-> gpd);

    // R7
    a_r7_ignore_in_transit: assert property (@(posedge clk) disable iff (rst)
        $past(gpd != gpo) |-> $stable(auto_vec));

    // R8
    a_r8_abort_keeps_on: assert property (@(posedge clk) disable iff (rst)
        $past(gpd && !gpo && grp_abort) |-> !gpo);

    // R10
    a_r10_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind rgp_pwr_ctrl rgp_checker #(
    .NUM_FRAMES(NUM_FRAMES),
    .UP_LAT    (UP_LAT),
    .DN_LAT    (DN_LAT)
) u_rgp_checker (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .rsp_valid(rsp_valid),
    .grp_abort(grp_abort),
    .gpd      (gpd),
    .gpo      (gpo),
    .frame_off(frame_off),
    .auto_vec (auto_vec)
);

// File: tb/test_rgp_pwr_ctrl.sv
`timescale 1ns/1ps
module test_rgp_pwr_ctrl;
    localparam int UPL = 5;
    localparam int DNL = 7;
    localparam logic [31:0] IDV = 32'h0300043B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        grp_abort = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model_cmp = 0;

    always #4 clk = ~clk;

    rgp_pwr_ctrl #(
        .NUM_FRAMES(4), .WIN_BITS(8), .UP_LAT(UPL), .DN_LAT(DNL), .ID_VALUE(IDV)
    ) i_rgp_pwr_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .grp_abort(grp_abort)
    );

    // ---------------- reference model (from the requirements) ----------------
    int m_grp;      // 0 off, 1 up, 2 on, 3 down
    int m_cnt;
    bit m_abf;
    bit m_req [4];
    bit m_on  [4];
    bit m_auto[4];
    bit        exp_valid;
    logic [31:0] exp_data;

    function automatic logic [31:0] m_word(int f);
        bit gd, go;
        gd = (m_grp == 3) || (m_grp == 0);
        go = (m_grp == 0) || (m_grp == 1);
        return {28'b0, go, gd, m_auto[f], !m_on[f]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_grp = 0; m_cnt = 0; m_abf = 0;
            for (int i = 0; i < 4; i++) begin m_req[i] = 0; m_on[i] = 0; m_auto[i] = 0; end
            exp_valid = 0; exp_data = 0;
        end else begin
            int  f;
            int  ofs;
            bit  stable, onw, offw, anyreq;
            f   = int'(req_addr[9:8]);
            ofs = int'(req_addr[7:0]);
            exp_valid = req_valid && !req_write;
            exp_data  = 0;
            if (exp_valid) begin
                if (ofs == 'h24) exp_data = m_word(f);
                else if (ofs == 'h08) exp_data = IDV;
            end
            stable = (m_grp == 0) || (m_grp == 2);
            onw = 0; offw = 0;
            if (req_valid && req_write && ofs == 'h24 && stable) begin
                m_auto[f] = req_wdata[1];
                if (req_wdata[0]) begin m_req[f] = 0; offw = 1; end
                else if (!req_wdata[1]) begin m_req[f] = 1; onw = 1; end
            end
            anyreq = 0;
            for (int i = 0; i < 4; i++) anyreq |= m_req[i];
            case (m_grp)
                0: if (onw) begin m_grp = 1; m_cnt = UPL - 1; end
                1: if (m_cnt == 0) m_grp = 2; else m_cnt--;
                2: if (offw && !anyreq) begin m_grp = 3; m_cnt = DNL - 1; m_abf = 0; end
                default: begin
                    m_abf |= grp_abort;
                    if (m_cnt == 0) begin m_grp = m_abf ? 2 : 0; m_abf = 0; end
                    else m_cnt--;
                end
            endcase
            for (int i = 0; i < 4; i++) m_on[i] = m_req[i] && (m_grp == 2);
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic w, input logic [9:0] a, input logic [31:0] d,
                       input logic ab, output logic [31:0] rd, output logic rv);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; grp_abort = ab;
        @(negedge clk);
        rd = rsp_rdata; rv = rsp_valid;
        if (model_cmp) begin
            check("R2 model valid", {31'b0, rv}, {31'b0, exp_valid});
            if (exp_valid) check("R2 model data", rd, exp_data);
        end
        req_valid = 1'b0; req_write = 1'b0; grp_abort = 1'b0;
    endtask

    task automatic wr(input int f, input int ofs, input logic [31:0] d);
        logic [31:0] rd; logic rv;
        cyc(1'b1, 1'b1, {f[1:0], ofs[7:0]}, d, 1'b0, rd, rv);
    endtask

    task automatic rdr(input int f, input int ofs, output logic [31:0] rd);
        logic rv;
        cyc(1'b1, 1'b0, {f[1:0], ofs[7:0]}, 32'h0, 1'b0, rd, rv);
    endtask

    task automatic poll_count(input int f, input logic [31:0] val, output int n, output logic [31:0] last);
        logic [31:0] rd;
        n = 0;
        for (int k = 0; k < 200; k++) begin
            rdr(f, 'h24, rd);
            if (rd == val) n++;
            else break;
        end
        last = rd;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] rd;
        logic        rv;
        int          n;
        int unsigned seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rdr(0, 'h24, rd); check("R1 frame0 reset", rd, 32'hD);
        rdr(3, 'h24, rd); check("R1 frame3 reset", rd, 32'hD);
        rdr(1, 'h08, rd); check("R3 id frame1", rd, IDV);
        rdr(2, 'h30, rd); check("R3 unmapped offset", rd, 32'h0);

        wr(0, 'h24, 32'h0);
        poll_count(0, 32'h9, n, rd);
        check("R4 up window length", n, UPL);
        check("R4 frame0 on at end", rd, 32'h0);
        rdr(1, 'h24, rd); check("R2 frame1 off group on", rd, 32'h1);

        wr(1, 'h24, 32'h0);
        rdr(1, 'h24, rd); check("R5 frame1 on next cycle", rd, 32'h0);
        wr(0, 'h24, 32'h1);
        rdr(0, 'h24, rd); check("R6 frame0 off, group stays on", rd, 32'h1);
        wr(2, 'h24, 32'h2);
        rdr(2, 'h24, rd); check("R9 select stored, no power-on", rd, 32'h3);

        wr(1, 'h24, 32'h1);
        poll_count(1, 32'h5, n, rd);
        check("R6 down window length", n, DNL);
        check("R6 group off after last frame", rd, 32'hD);

        wr(0, 'h24, 32'h0);
        wr(3, 'h24, 32'h2);
        wr(0, 'h24, 32'h1);
        poll_count(0, 32'h9, n, rd);
        check("R4 up window after ignored writes", n, UPL - 2);
        check("R7 off write in transit ignored", rd, 32'h0);
        rdr(3, 'h24, rd); check("R7 select write in transit ignored", rd, 32'h1);

        wr(0, 'h24, 32'h1);
        cyc(1'b0, 1'b0, 10'h0, 32'h0, 1'b1, rd, rv);
        poll_count(0, 32'h5, n, rd);
        check("R8 down window with abort", n, DNL - 1);
        check("R8 group back on after abort", rd, 32'h1);
        rdr(1, 'h24, rd); check("R8 group stable on", rd, 32'h1);

        wr(2, 'h24, 32'h0);
        rdr(2, 'h24, rd); check("R5 on after abort, select cleared", rd, 32'h0);
        wr(3, 'h28, 32'h1);
        wr(3, 'h08, 32'h0);
        rdr(3, 'h24, rd); check("R3 write to other offset no effect", rd, 32'h1);

        cyc(1'b1, 1'b1, {2'd3, 8'h30}, 32'h0, 1'b0, rd, rv);
        check("R10 no response to write", {31'b0, rv}, 32'h0);
        cyc(1'b1, 1'b0, {2'd1, 8'h08}, 32'h0, 1'b0, rd, rv);
        check("R10 response after read", {31'b0, rv}, 32'h1);
        check("R10 ready high", {31'b0, req_ready}, 32'h1);

        // constrained random phase against the model
        model_cmp = 1;
        for (int i = 0; i < 4000; i++) begin
            int unsigned sel;
            int unsigned f;
            int unsigned ofs;
            logic ab;
            sel = $urandom % 10;
            f   = $urandom % 4;
            ab  = (($urandom % 8) == 0);
            ofs = (($urandom % 8) == 0) ? 'h08 : 'h24;
            if (sel < 3)
                cyc(1'b1, 1'b1, {f[1:0], 8'h24}, $urandom % 4, ab, rd, rv);
            else if (sel < 8)
                cyc(1'b1, 1'b0, {f[1:0], ofs[7:0]}, 32'h0, ab, rd, rv);
            else
                cyc(1'b0, 1'b0, 10'h0, 32'h0, ab, rd, rv);
        end
        model_cmp = 0;

        finish_run();
    end
endmodule